// File: doc/BRIEF.md
# Carrier Board Control and Status Register Bank

This block is a word-addressed register bank for a carrier board. It gathers the board's identity words, its live status inputs and its power-supply controls behind one simple synchronous bus. The bus has an address, a write strobe, write data and read data. Reads are combinational from the address. A write takes effect on the clock edge where the strobe is high.

Some words are read-only. They hold fixed identity constants, or they mirror external input buses: the silicon ID halves, the bitstream date, the temperature, the status pins and a 64-word release tag. Other words can be written. These drive the supply enables, a monitor selector, a frequency setting and an adjustable-supply setting. The monitor selector picks which supply's voltage and current measurement is returned through a readback word.

The top bit of the supply control word is an action bit, not a stored bit. Writing 1 to it makes a small two-state strobe machine emit a one-cycle internal reset pulse. The two states are `ST_IDLE` and `ST_STROBE`. A write that sets the top bit moves the machine to `ST_STROBE`. It stays in `ST_STROBE` only while further such writes arrive, and returns to `ST_IDLE` on any other cycle.

Top module: `carrier_regbank`

## Requirements
- R1: After reset, address 0x00 reads 0x00010001 and address 0x03 reads 0x00000001. Addresses 0x07, 0x09 and 0x0A read 0. The ports supply_en, mon_sel, freq_ctl, vadj_ctl and soft_rst are all 0.
- R2: Five addresses mirror their input buses unchanged: 0x01 returns sid_lo, 0x02 returns sid_hi, 0x04 returns bs_date, 0x05 returns temp_in and 0x06 returns status_in.
- R3: A write to 0x07 stores two fields: bits [3:0] as the supply enables (driven on supply_en) and bits [11:8] as the monitor selector (driven on mon_sel). All other bits of 0x07 read 0.
- R4: A write to 0x07 with bit 31 set drives soft_rst high for exactly the one cycle after that write's edge. Bit 31 always reads 0. A write with bit 31 clear produces no pulse.
- R5: The soft_rst pulse does not clear any word of this bank. A write that sets bit 31 still stores its other fields.
- R6: Address 0x08 returns {current, voltage} for the selected supply. Current is in bits [31:16] and voltage in bits [15:0]. Selector values 0 to 3 pick supplies 0 to 3 (12V PCIe, 3V3 FMC, adjustable, 1V8). Selector values 4 to 15 return 0.
- R7: Addresses 0x09 and 0x0A are full 32-bit read/write words, driven on freq_ctl and vadj_ctl.
- R8: Addresses 0x40 to 0x7F return word (address − 0x40) of the rel_tag input. Word k occupies bits [32k+31:32k].
- R9: Writes to read-only or unmapped addresses change no word and no output. Reads of unmapped addresses (0x0B to 0x3F and 0x80 to 0xFF) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| sid_lo | input | 32 | Silicon ID, low word |
| sid_hi | input | 32 | Silicon ID, high word |
| bs_date | input | 32 | Bitstream build date |
| temp_in | input | 32 | Board temperature |
| status_in | input | 32 | Board and supply status pins |
| mon_volt | input | 64 | Four 16-bit supply voltage readings |
| mon_curr | input | 64 | Four 16-bit supply current readings |
| rel_tag | input | 2048 | Sixty-four 32-bit release tag words |
| supply_en | output | 4 | Supply enable bits |
| mon_sel | output | 4 | Monitor selector |
| freq_ctl | output | 32 | Frequency control word |
| vadj_ctl | output | 32 | Adjustable supply control word |
| soft_rst | output | 1 | One-cycle internal reset pulse |

## Verification
The hardest case to reach is a write that fires the reset pulse and loads new supply fields in the same cycle. A fault here would show as the bank wiping itself or losing the fields. The directed test writes bit 31 together with enable and selector values. It then checks the pulse in the cycle after the edge and its absence one cycle later. Finally it reads back the control word, the monitor readback and the frequency word to confirm nothing was cleared.

// File: rtl/carrier_pkg.sv
package carrier_pkg;
    // word addresses; decoded by software, so fixed
    localparam int A_TYPE     = 'h00;
    localparam int A_SID_LO   = 'h01;
    localparam int A_SID_HI   = 'h02;
    localparam int A_BS_TYPE  = 'h03;
    localparam int A_BS_DATE  = 'h04;
    localparam int A_TEMP     = 'h05;
    localparam int A_STATUS   = 'h06;
    localparam int A_SUP_CTL  = 'h07;
    localparam int A_SUP_MON  = 'h08;
    localparam int A_FREQ     = 'h09;
    localparam int A_VADJ     = 'h0A;
    localparam int A_TAG_BASE = 'h40;

    localparam logic [31:0] TYPE_WORD    = 32'h0001_0001;
    localparam logic [31:0] BS_TYPE_WORD = 32'h0000_0001;

    // supply control word field positions
    localparam int SUP_FIRE_BIT = 31;
    localparam int SUP_SEL_LSB  = 8;
    localparam int SUP_EN_LSB   = 0;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_STROBE = 1'b1
    } strobe_state_e;
endpackage

// File: rtl/carrier_ctl_regs.sv
module carrier_ctl_regs
    import carrier_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int EN_W   = 4,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [EN_W-1:0]   sup_en_q,
    output logic [SEL_W-1:0]  sup_sel_q,
    output logic [DATA_W-1:0] freq_q,
    output logic [DATA_W-1:0] vadj_q,
    output logic              strobe
);
    strobe_state_e state_q, state_d;
    logic hit_sup, hit_freq, hit_vadj, fire;
    logic wdata_unused;

    assign hit_sup  = wr_en && (int'(wr_addr) == A_SUP_CTL);
    assign hit_freq = wr_en && (int'(wr_addr) == A_FREQ);
    assign hit_vadj = wr_en && (int'(wr_addr) == A_VADJ);
    assign fire     = hit_sup && wr_data[SUP_FIRE_BIT];
    assign wdata_unused = ^{wr_data[30:16], wr_data[15:12], wr_data[7:4]};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: each firing write lasts one cycle in ST_STROBE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = fire ? ST_STROBE : ST_IDLE;
            ST_STROBE: state_d = fire ? ST_STROBE : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs of the strobe machine
    always_comb begin
        strobe = 1'b0;
        unique case (state_q)
            ST_IDLE:   strobe = 1'b0;
            ST_STROBE: strobe = 1'b1;
            default:   strobe = 1'b0;
        endcase
    end

    // storage; reset only by the external reset, never by strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sup_en_q  <= '0;
            sup_sel_q <= '0;
            freq_q    <= '0;
            vadj_q    <= '0;
        end else begin
            if (hit_sup) begin
                sup_en_q  <= wr_data[SUP_EN_LSB +: EN_W];
                sup_sel_q <= wr_data[SUP_SEL_LSB +: SEL_W];
            end
            if (hit_freq) freq_q <= wr_data;
            if (hit_vadj) vadj_q <= wr_data;
        end
    end
endmodule

// File: rtl/carrier_rd_mux.sv
module carrier_rd_mux
    import carrier_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int EN_W      = 4,
    parameter int SEL_W     = 4,
    parameter int NSUP      = 4,
    parameter int MON_W     = 16,
    parameter int TAG_WORDS = 64
) (
    input  logic [ADDR_W-1:0]           rd_addr,
    input  logic [EN_W-1:0]             sup_en_q,
    input  logic [SEL_W-1:0]            sup_sel_q,
    input  logic [DATA_W-1:0]           freq_q,
    input  logic [DATA_W-1:0]           vadj_q,
    input  logic [DATA_W-1:0]           sid_lo,
    input  logic [DATA_W-1:0]           sid_hi,
    input  logic [DATA_W-1:0]           bs_date,
    input  logic [DATA_W-1:0]           temp_in,
    input  logic [DATA_W-1:0]           status_in,
    input  logic [NSUP*MON_W-1:0]       mon_volt,
    input  logic [NSUP*MON_W-1:0]       mon_curr,
    input  logic [TAG_WORDS*DATA_W-1:0] rel_tag,
    output logic [DATA_W-1:0]           rd_data
);
    localparam int TAG_IDX_W = $clog2(TAG_WORDS);
    localparam int TAG_END   = A_TAG_BASE + TAG_WORDS;

    logic [DATA_W-1:0] mon_word [NSUP];
    logic [DATA_W-1:0] mon_sel_word;
    logic [DATA_W-1:0] sup_word;
    logic [TAG_IDX_W-1:0] tag_idx;
    logic in_tag;

    // one {current, voltage} word per supply
    for (genvar k = 0; k < NSUP; k++) begin : g_mon
        assign mon_word[k] = DATA_W'({mon_curr[k*MON_W +: MON_W],
                                      mon_volt[k*MON_W +: MON_W]});
    end

    always_comb begin
        mon_sel_word = '0;
        for (int k = 0; k < NSUP; k++)
            if (int'(sup_sel_q) == k) mon_sel_word = mon_word[k];
    end

    always_comb begin
        sup_word = '0;
        sup_word[SUP_EN_LSB +: EN_W]   = sup_en_q;
        sup_word[SUP_SEL_LSB +: SEL_W] = sup_sel_q;
    end

    assign in_tag  = (int'(rd_addr) >= A_TAG_BASE) && (int'(rd_addr) < TAG_END);
    assign tag_idx = TAG_IDX_W'(int'(rd_addr) - A_TAG_BASE);

    always_comb begin
        rd_data = '0;
        if (in_tag) rd_data = rel_tag[tag_idx*DATA_W +: DATA_W];
        else begin
            case (int'(rd_addr))
                A_TYPE:    rd_data = TYPE_WORD;
                A_SID_LO:  rd_data = sid_lo;
                A_SID_HI:  rd_data = sid_hi;
                A_BS_TYPE: rd_data = BS_TYPE_WORD;
                A_BS_DATE: rd_data = bs_date;
                A_TEMP:    rd_data = temp_in;
                A_STATUS:  rd_data = status_in;
                A_SUP_CTL: rd_data = sup_word;
                A_SUP_MON: rd_data = mon_sel_word;
                A_FREQ:    rd_data = freq_q;
                A_VADJ:    rd_data = vadj_q;
                default:   rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/carrier_regbank.sv
module carrier_regbank #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int EN_W      = 4,
    parameter int SEL_W     = 4,
    parameter int NSUP      = 4,
    parameter int MON_W     = 16,
    parameter int TAG_WORDS = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_wr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    input  logic [DATA_W-1:0]             sid_lo,
    input  logic [DATA_W-1:0]             sid_hi,
    input  logic [DATA_W-1:0]             bs_date,
    input  logic [DATA_W-1:0]             temp_in,
    input  logic [DATA_W-1:0]             status_in,
    input  logic [NSUP*MON_W-1:0]         mon_volt,
    input  logic [NSUP*MON_W-1:0]         mon_curr,
    input  logic [TAG_WORDS*DATA_W-1:0]   rel_tag,
    output logic [EN_W-1:0]               supply_en,
    output logic [SEL_W-1:0]              mon_sel,
    output logic [DATA_W-1:0]             freq_ctl,
    output logic [DATA_W-1:0]             vadj_ctl,
    output logic                          soft_rst
);
    carrier_ctl_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_W(EN_W), .SEL_W(SEL_W)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .wr_addr   (bus_addr),
        .wr_data   (bus_wdata),
        .sup_en_q  (supply_en),
        .sup_sel_q (mon_sel),
        .freq_q    (freq_ctl),
        .vadj_q    (vadj_ctl),
        .strobe    (soft_rst)
    );

    carrier_rd_mux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_W(EN_W), .SEL_W(SEL_W),
        .NSUP(NSUP), .MON_W(MON_W), .TAG_WORDS(TAG_WORDS)
    ) u_rd (
        .rd_addr   (bus_addr),
        .sup_en_q  (supply_en),
        .sup_sel_q (mon_sel),
        .freq_q    (freq_ctl),
        .vadj_q    (vadj_ctl),
        .sid_lo    (sid_lo),
        .sid_hi    (sid_hi),
        .bs_date   (bs_date),
        .temp_in   (temp_in),
        .status_in (status_in),
        .mon_volt  (mon_volt),
        .mon_curr  (mon_curr),
        .rel_tag   (rel_tag),
        .rd_data   (bus_rdata)
    );
endmodule

// File: rtl/carrier_regbank_chk.sv
module carrier_regbank_chk
    import carrier_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int EN_W   = 4,
    parameter int SEL_W  = 4,
    parameter int NSUP   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [EN_W-1:0]   supply_en,
    input logic [SEL_W-1:0]  mon_sel,
    input logic [DATA_W-1:0] freq_ctl,
    input logic [DATA_W-1:0] vadj_ctl,
    input logic              soft_rst
);
    logic fire_wr, sup_wr, ctl_wr;
    assign sup_wr  = bus_wr && (int'(bus_addr) == A_SUP_CTL);
    assign fire_wr = sup_wr && bus_wdata[SUP_FIRE_BIT];
    assign ctl_wr  = sup_wr || (bus_wr && (int'(bus_addr) == A_FREQ))
                            || (bus_wr && (int'(bus_addr) == A_VADJ));

    p_fire_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire_wr |=> soft_rst);

    p_pulse_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst && !fire_wr |=> !soft_rst);

    p_pulse_has_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_wr |=> !soft_rst);

    p_top_bit_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(bus_addr) == A_SUP_CTL |-> !bus_rdata[SUP_FIRE_BIT]);

    p_sup_fields_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_wr |=> $stable(supply_en) && $stable(mon_sel));

    p_pulse_keeps_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst && !ctl_wr |=> $stable(freq_ctl) && $stable(vadj_ctl)
                                && $stable(supply_en) && $stable(mon_sel));

    p_freq_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && int'(bus_addr) == A_FREQ |=> freq_ctl == $past(bus_wdata));

    p_vadj_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && int'(bus_addr) == A_VADJ |=> vadj_ctl == $past(bus_wdata));

    p_mon_out_of_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(bus_addr) == A_SUP_MON && int'(mon_sel) >= NSUP |-> bus_rdata == '0);

    p_ro_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && !ctl_wr |=> $stable(freq_ctl) && $stable(vadj_ctl)
                              && $stable(supply_en) && $stable(mon_sel));
endmodule

bind carrier_regbank carrier_regbank_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_W(EN_W), .SEL_W(SEL_W), .NSUP(NSUP)
) u_chk (.*);

// File: tb/carrier_regbank_bench.sv
module carrier_regbank_bench;
    localparam int NSUP = 4, MON_W = 16, TAG_WORDS = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] sid_lo = 32'h1111_2222, sid_hi = 32'h3333_4444;
    logic [31:0] bs_date = 32'h4C88_1234, temp_in = 32'h0000_0199;
    logic [31:0] status_in = 32'h0000_00A5;
    logic [NSUP*MON_W-1:0] mon_volt, mon_curr;
    logic [TAG_WORDS*32-1:0] rel_tag;
    logic [3:0]  supply_en, mon_sel;
    logic [31:0] freq_ctl, vadj_ctl;
    logic        soft_rst;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    initial begin
        for (int k = 0; k < NSUP; k++) begin
            mon_volt[k*MON_W +: MON_W] = 16'h1000 + 16'(k);
            mon_curr[k*MON_W +: MON_W] = 16'h2000 + 16'(k);
        end
        for (int k = 0; k < TAG_WORDS; k++)
            rel_tag[k*32 +: 32] = 32'hC0DE_0000 + 32'(k);
    end

    carrier_regbank u_carrier_regbank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sid_lo(sid_lo),
        .sid_hi(sid_hi), .bs_date(bs_date), .temp_in(temp_in),
        .status_in(status_in), .mon_volt(mon_volt), .mon_curr(mon_curr),
        .rel_tag(rel_tag), .supply_en(supply_en), .mon_sel(mon_sel),
        .freq_ctl(freq_ctl), .vadj_ctl(vadj_ctl), .soft_rst(soft_rst)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 24;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 8'h00, 32'h0, 32'h0001_0001, 4'd1},  // R1 type word
        '{1'b0, 8'h03, 32'h0, 32'h0000_0001, 4'd1},  // R1 bitstream type
        '{1'b0, 8'h07, 32'h0, 32'h0000_0000, 4'd1},  // R1 supply control
        '{1'b0, 8'h01, 32'h0, 32'h1111_2222, 4'd2},  // R2
        '{1'b0, 8'h02, 32'h0, 32'h3333_4444, 4'd2},  // R2
        '{1'b0, 8'h04, 32'h0, 32'h4C88_1234, 4'd2},  // R2
        '{1'b0, 8'h05, 32'h0, 32'h0000_0199, 4'd2},  // R2
        '{1'b0, 8'h06, 32'h0, 32'h0000_00A5, 4'd2},  // R2
        '{1'b1, 8'h07, 32'h7FFF_FFFF, 32'h0000_0F0F, 4'd3},  // R3 masks
        '{1'b0, 8'h08, 32'h0, 32'h0000_0000, 4'd6},  // R6 sel 15
        '{1'b1, 8'h07, 32'h0000_0200, 32'h2002_1002, 4'd6}, // R6 (read 0x08)
        '{1'b1, 8'h07, 32'h0000_0000, 32'h2000_1000, 4'd6}, // R6
        '{1'b1, 8'h07, 32'h0000_0300, 32'h2003_1003, 4'd6}, // R6
        '{1'b1, 8'h07, 32'h0000_0400, 32'h0000_0000, 4'd6}, // R6 sel 4
        '{1'b1, 8'h09, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'd7}, // R7
        '{1'b1, 8'h0A, 32'h1234_5678, 32'h1234_5678, 4'd7}, // R7
        '{1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0001_0001, 4'd9}, // R9
        '{1'b1, 8'h05, 32'h0000_0000, 32'h0000_0199, 4'd9}, // R9
        '{1'b1, 8'h20, 32'h0000_FFFF, 32'h0000_0000, 4'd9}, // R9
        '{1'b0, 8'h40, 32'h0, 32'hC0DE_0000, 4'd8},  // R8 first
        '{1'b0, 8'h7F, 32'h0, 32'hC0DE_003F, 4'd8},  // R8 last
        '{1'b0, 8'h80, 32'h0, 32'h0000_0000, 4'd9},  // R9 unmapped
        '{1'b1, 8'h45, 32'hFFFF_FFFF, 32'hC0DE_0005, 4'd9}, // R9
        '{1'b0, 8'h09, 32'h0, 32'hDEAD_BEEF, 4'd9}   // R9 untouched
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #2;
        d = bus_rdata;
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        check("R1 soft_rst in reset", {31'b0, soft_rst}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 supply_en", {28'b0, supply_en}, 32'h0);
        check("R1 mon_sel", {28'b0, mon_sel}, 32'h0);
        check("R1 freq_ctl", freq_ctl, 32'h0);
        check("R1 vadj_ctl", vadj_ctl, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].wr) bus_write(VEC[i].addr, VEC[i].data);
            else @(negedge clk);
            // monitor writes are verified through the readback word
            if (VEC[i].wr && VEC[i].addr == 8'h07 && VEC[i].req == 4'd6)
                bus_read(8'h08, rd);
            else
                bus_read(VEC[i].addr, rd);
            check($sformatf("R%0d vec%0d", VEC[i].req, i), rd, VEC[i].exp);
        end
        check("R7 vadj_ctl port", vadj_ctl, 32'h1234_5678);

        // R4: write without bit 31 gives no pulse
        bus_write(8'h07, 32'h0000_0001);
        check("R4 no pulse", {31'b0, soft_rst}, 32'h0);

        // R4/R5: firing write with fields in the same word
        @(negedge clk);
        bus_addr = 8'h07; bus_wdata = 32'h8000_0103; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R4 pulse high", {31'b0, soft_rst}, 32'h1);
        @(negedge clk);
        check("R4 pulse one cycle", {31'b0, soft_rst}, 32'h0);
        bus_read(8'h07, rd);
        check("R4 top bit reads 0 / R5 fields kept", rd, 32'h0000_0103);
        check("R5 supply_en", {28'b0, supply_en}, 32'h3);
        bus_read(8'h08, rd);
        check("R5 R6 readback sel 1", rd, 32'h2001_1001);
        bus_read(8'h09, rd);
        check("R5 freq kept", rd, 32'hDEAD_BEEF);

        // R4: back-to-back firing writes, one pulse each
        @(negedge clk);
        bus_addr = 8'h07; bus_wdata = 32'h8000_0000; bus_wr = 1'b1;
        @(negedge clk);
        check("R4 b2b first", {31'b0, soft_rst}, 32'h1);
        @(negedge clk);
        bus_wr = 1'b0;
        check("R4 b2b second", {31'b0, soft_rst}, 32'h1);
        @(negedge clk);
        check("R4 b2b end", {31'b0, soft_rst}, 32'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule